// File: doc/BRIEF.md
# Address Bus Arbiter with Idle Parking

This block decides which of up to eight bus masters owns the address bus. Each master raises its request line; the arbiter answers with a one-hot grant. The grant stays with its owner until that master's address tenure finishes, and the finish is signalled by a strobe. When several masters compete, the lowest-numbered one wins. The one exception is a master that already holds a parked grant: it keeps the bus.

When no address tenure is active, the arbiter can leave the bus parked on one master. A parked master that then requests starts its tenure without any turnaround cycle. There are three parking policies: no parking, park on the master granted most recently, or park on a master chosen by software. A pipeline-disable control selects how address tenures relate to data tenures. When it is set, the next grant waits until every data tenure has completed. When it is clear, one new address tenure may overlap a data tenure that is still running. The control word is written in one cycle over a plain write strobe.

Top module: `bus_park_arbiter`

## Requirements
- R1: After reset the parking mode is none, the pipeline-disable bit is 1, `grant` is all zero and `parked` is 0.
- R2: When no active tenure exists and parking does not apply, the requesting master with the lowest index is granted. The grant appears in the cycle after the request is first seen, and it stays asserted for as long as the address tenure lasts.
- R3: The grant stays with its owner, unchanged, until a cycle in which `addr_done` is high. In the following cycle the tenure is over, and one data tenure becomes outstanding.
- R4: While pipeline-disable (`cfg_wr_data[5]`) is 1 and any data tenure is outstanding, no grant is asserted, not even a parked one. Granting resumes in the cycle after the `data_done` strobe.
- R5: While pipeline-disable is 0, a new address tenure may begin while one data tenure is outstanding. With two data tenures outstanding, no grant is given.
- R6: Parking mode field `cfg_wr_data[1:0]` set to 00 (none) or to 01 (reserved, treated as none) leaves `grant` at zero whenever no tenure is active.
- R7: Mode 11 parks on the master whose index is in `cfg_wr_data[4:2]`. The block then drives that master's grant bit with `parked` at 1.
- R8: Mode 10 parks on the master granted most recently. This applies only once at least one grant has been issued since reset.
- R9: A parked master that requests keeps its grant with no gap, even when a lower-index master also requests. Its tenure begins at the next clock edge.
- R10: `grant` never has more than one bit set, and `parked` is high only when exactly one grant bit is set and no tenure is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 8 | Request line per master |
| addr_done | input | 1 | Strobe: current address tenure ends this cycle |
| data_done | input | 1 | Strobe: the oldest outstanding data tenure ends this cycle |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 6 | Control word: [1:0] parking mode, [4:2] parked index, [5] pipeline disable |
| grant | output | 8 | One-hot grant, registered state only |
| parked | output | 1 | Grant shown without an active tenure |

## Verification
If the owner register is corrupted, the grant bit moves in the middle of a tenure. The bad grant is visible in the first cycle after the fault. If the outstanding-tenure count is wrong, the grant shows up too early or never comes after a done strobe. With pipelining disabled this appears in the cycle right after `addr_done`. A stale most-recent index or a wrong priority decode shows as the wrong one-hot bit during the first idle or arbitration cycle. The bench therefore compares the exact grant and parked values in every cycle of each scenario, rather than only at the ends of transactions.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  typedef enum logic [1:0] {
    PARK_NONE = 2'b00,
    PARK_RSVD = 2'b01,
    PARK_LAST = 2'b10,
    PARK_PROG = 2'b11
  } park_mode_e;
endpackage

// File: rtl/bpa_cfg_reg.sv
module bpa_cfg_reg
  import bpa_pkg::*;
#(
  parameter int IDXW = 3,
  localparam int CFGW = IDXW + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CFGW-1:0] wr_data,
  output park_mode_e      mode,
  output logic [IDXW-1:0] prog_idx,
  output logic            pipe_dis
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= PARK_NONE;
      prog_idx <= '0;
      pipe_dis <= 1'b1;
    end else if (wr_en) begin
      mode     <= park_mode_e'(wr_data[1:0]);
      prog_idx <= wr_data[IDXW+1:2];
      pipe_dis <= wr_data[IDXW+2];
    end
  end
endmodule

// File: rtl/bpa_prio_pick.sv
module bpa_prio_pick #(
  parameter int N    = 8,
  parameter int IDXW = 3
) (
  input  logic [N-1:0]    req,
  output logic            any,
  output logic [IDXW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDXW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/bpa_tenure_track.sv
module bpa_tenure_track #(
  parameter int MAXO = 2,
  localparam int CW = $clog2(MAXO + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_end,
  input  logic          data_end,
  input  logic          pipe_dis,
  output logic [CW-1:0] outstanding,
  output logic          start_ok
);
  logic          dec;
  logic [CW-1:0] limit;

  assign dec   = data_end && (outstanding != '0);
  assign limit = pipe_dis ? CW'(1) : CW'(MAXO);
  assign start_ok = outstanding < limit;

  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= '0;
    else outstanding <= outstanding + CW'(addr_end) - CW'(dec);
  end
endmodule

// File: rtl/bus_park_arbiter.sv
module bus_park_arbiter
  import bpa_pkg::*;
#(
  parameter int NUM_MASTERS     = 8,
  parameter int MAX_OUTSTANDING = 2,
  localparam int IDXW  = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  localparam int CFGW  = IDXW + 3,
  localparam int CNT_W = $clog2(MAX_OUTSTANDING + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic                   addr_done,
  input  logic                   data_done,
  input  logic                   cfg_wr_en,
  input  logic [CFGW-1:0]        cfg_wr_data,
  output logic [NUM_MASTERS-1:0] grant,
  output logic                   parked
);
  park_mode_e       cfg_mode;
  logic [IDXW-1:0]  cfg_idx;
  logic             cfg_pipe_dis;
  logic [CNT_W-1:0] outstanding;
  logic             start_ok;
  logic             pick_any;
  logic [IDXW-1:0]  pick_idx;

  logic             in_addr;
  logic [IDXW-1:0]  owner;
  logic [IDXW-1:0]  last_idx;
  logic             last_vld;

  logic             park_en;
  logic [IDXW-1:0]  park_idx;
  logic [IDXW-1:0]  win_idx;
  logic             start;
  logic             show_vld;
  logic [IDXW-1:0]  show_idx;

  bpa_cfg_reg #(.IDXW(IDXW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .mode(cfg_mode), .prog_idx(cfg_idx), .pipe_dis(cfg_pipe_dis)
  );

  bpa_prio_pick #(.N(NUM_MASTERS), .IDXW(IDXW)) u_pick (
    .req(req), .any(pick_any), .idx(pick_idx)
  );

  bpa_tenure_track #(.MAXO(MAX_OUTSTANDING)) u_trk (
    .clk(clk), .rst_n(rst_n), .addr_end(in_addr && addr_done),
    .data_end(data_done), .pipe_dis(cfg_pipe_dis),
    .outstanding(outstanding), .start_ok(start_ok)
  );

  // Parking target: programmed index (if in range) or the last owner.
  always_comb begin
    park_idx = (cfg_mode == PARK_PROG) ? cfg_idx : last_idx;
    unique case (cfg_mode)
      PARK_PROG: park_en = start_ok && (32'(cfg_idx) < NUM_MASTERS);
      PARK_LAST: park_en = start_ok && last_vld;
      default:   park_en = 1'b0;
    endcase
  end

  assign win_idx  = (park_en && req[park_idx]) ? park_idx : pick_idx;
  assign start    = !in_addr && start_ok && pick_any;
  assign show_vld = in_addr || park_en;
  assign show_idx = in_addr ? owner : park_idx;
  assign parked   = !in_addr && park_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_addr  <= 1'b0;
      owner    <= '0;
      last_idx <= '0;
      last_vld <= 1'b0;
    end else if (start) begin
      in_addr  <= 1'b1;
      owner    <= win_idx;
      last_idx <= win_idx;
      last_vld <= 1'b1;
    end else if (in_addr && addr_done) begin
      in_addr  <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_grant
    assign grant[g] = show_vld && (show_idx == IDXW'(g));
  end
endmodule

// File: rtl/bpa_checker.sv
module bpa_checker #(
  parameter int N  = 8,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  req,
  input logic          addr_done,
  input logic [N-1:0]  grant,
  input logic          parked,
  input logic          in_addr,
  input logic          pipe_dis,
  input logic [1:0]    mode,
  input logic [CW-1:0] outstanding
);
  // R10
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R10
  parked_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parked |-> ($countones(grant) == 1 && !in_addr));

  // R3
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_addr && !addr_done) |=> $stable(grant));

  // R4
  pipe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_addr && pipe_dis && outstanding != '0) |-> grant == '0);

  // R6
  no_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_addr && !mode[1]) |-> grant == '0);

  // R9
  park_seamless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && (grant & req) != '0) |=> (grant == $past(grant) && in_addr));
endmodule

bind bus_park_arbiter bpa_checker #(.N(NUM_MASTERS), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .addr_done(addr_done),
  .grant(grant), .parked(parked), .in_addr(in_addr),
  .pipe_dis(cfg_pipe_dis), .mode(cfg_mode), .outstanding(outstanding)
);

// File: tb/bus_park_arbiter_test.sv
module bus_park_arbiter_test;
  localparam int CLK_P = 10;

  typedef struct {
    logic [7:0] g;
    logic       p;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic       addr_done = 1'b0;
  logic       data_done = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [5:0] cfg_wr_data = '0;
  logic [7:0] grant;
  logic       parked;

  int checks = 0;
  int failures = 0;
  exp_t sb[$];

  always #(CLK_P/2) clk = ~clk;

  bus_park_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req(req), .addr_done(addr_done),
    .data_done(data_done), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .grant(grant), .parked(parked)
  );

  // Driver: one cycle of stimulus plus the expected outputs in that cycle.
  task automatic cyc(input logic [7:0] r, input logic ad, input logic dd,
                     input logic [7:0] eg, input logic ep, input string tag);
    exp_t e;
    @(negedge clk);
    req = r; addr_done = ad; data_done = dd; cfg_wr_en = 1'b0;
    e.g = eg; e.p = ep; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wcfg(input logic [1:0] mode, input logic [2:0] idx, input logic pd);
    @(negedge clk);
    req = '0; addr_done = 1'b0; data_done = 1'b0;
    cfg_wr_en = 1'b1; cfg_wr_data = {pd, idx, mode};
  endtask

  // Monitor: compare mid-cycle against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (grant !== e.g || parked !== e.p) begin
          failures++;
          $display("FAIL %s: grant=%h parked=%b expected grant=%h parked=%b",
                   e.tag, grant, parked, e.g, e.p);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    checks++; failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cyc(8'h00, 0, 0, 8'h00, 0, "R1");
    // R2 priority: masters 2 and 4 request, 2 wins
    cyc(8'h14, 0, 0, 8'h00, 0, "R6");
    cyc(8'h14, 1, 0, 8'h04, 0, "R2");
    // R4 pipeline disabled: held until data_done
    cyc(8'h10, 0, 0, 8'h00, 0, "R4");
    cyc(8'h10, 0, 1, 8'h00, 0, "R4");
    cyc(8'h10, 0, 0, 8'h00, 0, "R2");
    cyc(8'h00, 0, 0, 8'h10, 0, "R3");
    cyc(8'h00, 1, 0, 8'h10, 0, "R3");
    cyc(8'h00, 0, 1, 8'h00, 0, "R4");
    cyc(8'h00, 0, 0, 8'h00, 0, "R6");
    // R7 programmed park on master 5
    wcfg(2'b11, 3'd5, 1'b1);
    cyc(8'h00, 0, 0, 8'h20, 1, "R7");
    cyc(8'h21, 0, 0, 8'h20, 1, "R9");
    cyc(8'h01, 1, 0, 8'h20, 0, "R9");
    cyc(8'h01, 0, 0, 8'h00, 0, "R4");
    cyc(8'h01, 0, 1, 8'h00, 0, "R4");
    cyc(8'h01, 0, 0, 8'h20, 1, "R7");
    cyc(8'h00, 1, 0, 8'h01, 0, "R2");
    cyc(8'h00, 0, 1, 8'h00, 0, "R4");
    cyc(8'h00, 0, 0, 8'h20, 1, "R7");
    // R5 pipelining enabled, no parking
    wcfg(2'b00, 3'd0, 1'b0);
    cyc(8'h02, 0, 0, 8'h00, 0, "R6");
    cyc(8'h08, 1, 0, 8'h02, 0, "R2");
    cyc(8'h08, 0, 0, 8'h00, 0, "R5");
    cyc(8'h00, 1, 0, 8'h08, 0, "R5");
    cyc(8'h40, 0, 0, 8'h00, 0, "R5");
    cyc(8'h40, 0, 1, 8'h00, 0, "R5");
    cyc(8'h40, 0, 0, 8'h00, 0, "R5");
    cyc(8'h00, 1, 1, 8'h40, 0, "R5");
    cyc(8'h00, 0, 1, 8'h00, 0, "R5");
    // R8 park on most recent master (6)
    wcfg(2'b10, 3'd0, 1'b0);
    cyc(8'h00, 0, 0, 8'h40, 1, "R8");
    cyc(8'h44, 0, 0, 8'h40, 1, "R9");
    cyc(8'h00, 1, 0, 8'h40, 0, "R3");
    cyc(8'h00, 0, 0, 8'h40, 1, "R8");
    cyc(8'h04, 0, 0, 8'h40, 1, "R8");
    cyc(8'h00, 1, 1, 8'h04, 0, "R2");
    cyc(8'h00, 0, 0, 8'h04, 1, "R8");
    cyc(8'h00, 0, 1, 8'h04, 1, "R8");
    // R6 reserved code acts as no parking
    wcfg(2'b01, 3'd5, 1'b1);
    cyc(8'h00, 0, 0, 8'h00, 0, "R6");
    cyc(8'h00, 0, 0, 8'h00, 0, "R6");
    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R10 scoreboard: pending=%0d expected=0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule